// File: doc/BRIEF.md
# Single-Wire ROM Command Layer

This block is the addressing layer of a single-wire bus slave. It sits between the bit-slot engine, which turns line activity into one sampled bit per time slot, and the memory-command layer, which may only act once this block has granted access. After every bus reset event it collects an 8-bit ROM command, least significant bit first, and executes it against a 64-bit identity. The identity is the family byte (2Dh by default) in bits 7:0, a 48-bit serial number in bits 55:8, and a check byte in bits 63:56. Both the family byte and the serial number are parameters. A small serial generator computes the check byte after power-on reset.

The slot interface uses valid/ready. Before each slot, `tx_bit_o` gives the level the slave leaves on the line: 1 means released, 0 means pulled low. The bit engine samples the wired-AND of master and slave and delivers it on `slot_bit_i` with `slot_valid_i`. A slot is consumed on a cycle where `slot_valid_i` and `slot_ready_o` are both high. The engine must hold `slot_valid_i` and `slot_bit_i` steady until then. `slot_ready_o` stays low until the check byte is ready and stays high from then on. `tx_bit_o` changes only after a consumed slot or a bus reset event.

The block supports five commands: identity read, identity match, binary-tree search, unconditional select and fast reselect. A reselect flag lets a slave that was chosen by a full match or search be chosen again without sending its identity. On completion the block either raises `sel_o` toward the memory layer or parks in a wait-for-reset state shown on `wait_o`.

Top module: `onew_rom_select`

## Requirements
- R1: The identity is sent least significant bit first: bits 7:0 are the family byte, bits 55:8 the serial number, bits 63:56 a check byte. The check byte is built from zero over bits 0..55 with the polynomial x^8+x^5+x^4+1, shifting right with feedback mask 8Ch. Running the same generator over all 64 bits leaves zero.
- R2: After power-on reset `slot_ready_o` is low for exactly 55 clock edges and high from the 56th edge on. No slot is consumed while it is low.
- R3: After a bus reset event the next 8 consumed slots form the command, first slot as bit 0. Recognised codes: 33h read, 55h match, F0h search, CCh select-all, A5h reselect.
- R4: Read sends the 64 identity bits on `tx_bit_o`, one per slot. After the last bit `sel_o` rises. Read clears the reselect flag.
- R5: Match compares 64 received bits with the identity. If all agree, `sel_o` rises and the reselect flag is set. At the first disagreeing bit the block goes to wait-for-reset.
- R6: Search uses three slots per identity bit: the true bit, then its complement, then a slot whose received value is the master's choice. A choice that differs from the own bit sends the block to wait-for-reset. After 64 agreeing choices `sel_o` rises and the reselect flag is set.
- R7: Select-all raises `sel_o` right after the command byte, without looking at any identity bit, and clears the reselect flag.
- R8: Reselect raises `sel_o` when the reselect flag is set. Otherwise it goes to wait-for-reset.
- R9: Any other command code goes to wait-for-reset.
- R10: A bus reset event in any state returns the block to command collection. The reselect flag keeps its value across it.
- R11: While the block is not sending identity bits, `tx_bit_o` is 1, including in wait-for-reset and while selected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-on reset |
| bus_rst_i | input | 1 | One-cycle pulse: bus reset event seen on the line |
| slot_valid_i | input | 1 | A sampled slot is presented |
| slot_ready_o | output | 1 | Block accepts slots (identity check byte ready) |
| slot_bit_i | input | 1 | Sampled line level of the slot (wired-AND) |
| tx_bit_o | output | 1 | Level the slave leaves on the line in the next slot; 1 = released |
| sel_o | output | 1 | Memory layer is granted access |
| wait_o | output | 1 | Block is waiting for a bus reset event |

## Verification
All 256 command codes are applied after a bus reset. This separates the five recognised codes from every other value and shows that the byte is taken in LSB-first order. Identity match and search are each driven once with a fully agreeing master and once with a single flipped bit at every one of the 64 positions. This pins down the exact slot where the slave drops out and shows that it releases the line afterwards. Sequences of select-all, completed match, interrupted match and reselect show whether the reselect flag is cleared, set and kept at the right moments. The read-back identity is checked against a check byte computed in the bench.

// File: rtl/onew_rom_pkg.sv
package onew_rom_pkg;

  typedef enum logic [2:0] {
    ST_WAIT,
    ST_CMD,
    ST_READ,
    ST_MATCH,
    ST_SEARCH,
    ST_SEL
  } rom_state_e;

  localparam logic [7:0] OP_READ    = 8'h33;
  localparam logic [7:0] OP_MATCH   = 8'h55;
  localparam logic [7:0] OP_SEARCH  = 8'hF0;
  localparam logic [7:0] OP_SELALL  = 8'hCC;
  localparam logic [7:0] OP_RESEL   = 8'hA5;

  localparam logic [7:0] CHK_MASK   = 8'h8C;

  function automatic logic [7:0] chk_step(input logic [7:0] acc, input logic din);
    logic fb;
    fb = acc[0] ^ din;
    return {1'b0, acc[7:1]} ^ (fb ? CHK_MASK : 8'h00);
  endfunction

endpackage

// File: rtl/onew_id_crc.sv
module onew_id_crc #(
  parameter int DATA_BITS = 56
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [DATA_BITS-1:0] data_i,
  output logic [7:0]           crc_o,
  output logic                 done_o
);
  import onew_rom_pkg::*;

  localparam int CW = $clog2(DATA_BITS + 1);
  localparam logic [CW-1:0] END_CNT = CW'(DATA_BITS);

  logic [CW-1:0] cnt_q;
  logic [7:0]    acc_q;

  assign done_o = (cnt_q == END_CNT);
  assign crc_o  = acc_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      acc_q <= '0;
    end else if (!done_o) begin
      acc_q <= chk_step(acc_q, data_i[cnt_q]);
      cnt_q <= cnt_q + 1'b1;
    end
  end

  AST_CHK_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> (done_o && $stable(acc_q))); // R1

endmodule

// File: rtl/onew_rom_seq.sv
module onew_rom_seq #(
  parameter int ID_BITS = 64
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_rst_i,
  input  logic               slot_fire_i,
  input  logic               slot_bit_i,
  input  logic [ID_BITS-1:0] id_i,
  output logic               tx_bit_o,
  output logic               sel_o,
  output logic               wait_o
);
  import onew_rom_pkg::*;

  localparam int IW = $clog2(ID_BITS);
  localparam logic [IW-1:0] LAST_IDX = IW'(ID_BITS - 1);

  rom_state_e    state_q, state_d;
  logic [IW-1:0] idx_q, idx_d;
  logic [1:0]    phase_q, phase_d;
  logic [7:0]    cmd_q, cmd_d;
  logic [2:0]    ccnt_q, ccnt_d;
  logic          rc_q, rc_d;
  logic          own_bit;
  logic [7:0]    cmd_full;

  assign own_bit  = id_i[idx_q];
  assign cmd_full = {slot_bit_i, cmd_q[7:1]};

  always_comb begin
    tx_bit_o = 1'b1;
    if (state_q == ST_READ) begin
      tx_bit_o = own_bit;
    end else if (state_q == ST_SEARCH) begin
      if (phase_q == 2'd0)      tx_bit_o = own_bit;
      else if (phase_q == 2'd1) tx_bit_o = ~own_bit;
    end
  end

  assign sel_o  = (state_q == ST_SEL);
  assign wait_o = (state_q == ST_WAIT);

  always_comb begin
    state_d = state_q;
    idx_d   = idx_q;
    phase_d = phase_q;
    cmd_d   = cmd_q;
    ccnt_d  = ccnt_q;
    rc_d    = rc_q;
    if (bus_rst_i) begin
      state_d = ST_CMD;
      idx_d   = '0;
      phase_d = '0;
      cmd_d   = '0;
      ccnt_d  = '0;
    end else if (slot_fire_i) begin
      unique case (state_q)
        ST_CMD: begin
          cmd_d  = cmd_full;
          ccnt_d = ccnt_q + 1'b1;
          if (ccnt_q == 3'd7) begin
            unique case (cmd_full)
              OP_READ:   begin state_d = ST_READ;   rc_d = 1'b0; end
              OP_MATCH:  begin state_d = ST_MATCH;  rc_d = 1'b0; end
              OP_SEARCH: begin state_d = ST_SEARCH; rc_d = 1'b0; end
              OP_SELALL: begin state_d = ST_SEL;    rc_d = 1'b0; end
              OP_RESEL:  state_d = rc_q ? ST_SEL : ST_WAIT;
              default:   state_d = ST_WAIT;
            endcase
          end
        end
        ST_READ: begin
          if (idx_q == LAST_IDX) state_d = ST_SEL;
          else                   idx_d   = idx_q + 1'b1;
        end
        ST_MATCH: begin
          if (slot_bit_i != own_bit) begin
            state_d = ST_WAIT;
          end else if (idx_q == LAST_IDX) begin
            state_d = ST_SEL;
            rc_d    = 1'b1;
          end else begin
            idx_d = idx_q + 1'b1;
          end
        end
        ST_SEARCH: begin
          if (phase_q != 2'd2) begin
            phase_d = phase_q + 1'b1;
          end else begin
            phase_d = 2'd0;
            if (slot_bit_i != own_bit) begin
              state_d = ST_WAIT;
            end else if (idx_q == LAST_IDX) begin
              state_d = ST_SEL;
              rc_d    = 1'b1;
            end else begin
              idx_d = idx_q + 1'b1;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_WAIT;
      idx_q   <= '0;
      phase_q <= '0;
      cmd_q   <= '0;
      ccnt_q  <= '0;
      rc_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
      phase_q <= phase_d;
      cmd_q   <= cmd_d;
      ccnt_q  <= ccnt_d;
      rc_q    <= rc_d;
    end
  end

  AST_RESET_TO_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rst_i |=> (state_q == ST_CMD)); // R10

  AST_RC_KEPT_ON_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rst_i |=> (rc_q == $past(rc_q))); // R10

  AST_RC_SET_BY_ID: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rc_q) |-> ($past(state_q) == ST_MATCH || $past(state_q) == ST_SEARCH)); // R5

  AST_WAIT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (wait_o && !bus_rst_i) |=> wait_o); // R9

  AST_SEL_AFTER_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sel_o) |-> $past(slot_fire_i)); // R4

  AST_SEL_WAIT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(sel_o && wait_o)); // R11

endmodule

// File: rtl/onew_rom_select.sv
module onew_rom_select #(
  parameter logic [7:0]  FAMILY = 8'h2D,
  parameter logic [47:0] SERIAL = 48'h5E7A_91C3_0B46
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bus_rst_i,
  input  logic slot_valid_i,
  output logic slot_ready_o,
  input  logic slot_bit_i,
  output logic tx_bit_o,
  output logic sel_o,
  output logic wait_o
);
  localparam int BODY_BITS = $bits(FAMILY) + $bits(SERIAL);
  localparam int ID_BITS   = BODY_BITS + 8;

  logic [BODY_BITS-1:0] body;
  logic [7:0]           chk;
  logic                 chk_done;
  logic [ID_BITS-1:0]   ident;
  logic                 fire;

  assign body  = {SERIAL, FAMILY};
  assign ident = {chk, body};
  assign slot_ready_o = chk_done;
  assign fire  = slot_valid_i && slot_ready_o;

  onew_id_crc #(.DATA_BITS(BODY_BITS)) i_crc (
    .clk    (clk),
    .rst_n  (rst_n),
    .data_i (body),
    .crc_o  (chk),
    .done_o (chk_done)
  );

  onew_rom_seq #(.ID_BITS(ID_BITS)) i_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_rst_i   (bus_rst_i),
    .slot_fire_i (fire),
    .slot_bit_i  (slot_bit_i),
    .id_i        (ident),
    .tx_bit_o    (tx_bit_o),
    .sel_o       (sel_o),
    .wait_o      (wait_o)
  );

  AST_READY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    slot_ready_o |=> slot_ready_o); // R2

  AST_NO_GRANT_UNREADY: assert property (@(posedge clk) disable iff (!rst_n)
    !slot_ready_o |-> (!sel_o && tx_bit_o)); // R2

endmodule

// File: tb/test_onew_rom_select.sv
module test_onew_rom_select;
  localparam int CLK_P = 10;
  localparam logic [7:0]  FAM = 8'h2D;
  localparam logic [47:0] SER = 48'h5E7A_91C3_0B46;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_rst_i = 1'b0;
  logic slot_valid_i = 1'b0;
  logic slot_bit_i = 1'b1;
  logic slot_ready_o, tx_bit_o, sel_o, wait_o;

  int nvec = 0;
  int nerr = 0;
  logic [63:0] exp_id;

  always #(CLK_P/2) clk = ~clk;

  onew_rom_select #(.FAMILY(FAM), .SERIAL(SER)) i_onew_rom_select (
    .clk(clk), .rst_n(rst_n), .bus_rst_i(bus_rst_i),
    .slot_valid_i(slot_valid_i), .slot_ready_o(slot_ready_o),
    .slot_bit_i(slot_bit_i), .tx_bit_o(tx_bit_o),
    .sel_o(sel_o), .wait_o(wait_o)
  );

  function automatic logic [7:0] ref_chk(input logic [63:0] v, input int n);
    logic [7:0] a;
    a = 8'h00;
    for (int i = 0; i < n; i++) begin
      if (a[0] ^ v[i]) a = (a >> 1) ^ 8'h8C;
      else             a = a >> 1;
    end
    return a;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    nvec++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic slot(input logic mb, output logic obs);
    obs = mb & tx_bit_o;
    slot_valid_i = 1'b1;
    slot_bit_i = obs;
    @(negedge clk);
    slot_valid_i = 1'b0;
    slot_bit_i = 1'b1;
  endtask

  task automatic bus_reset();
    bus_rst_i = 1'b1;
    @(negedge clk);
    bus_rst_i = 1'b0;
  endtask

  task automatic send_cmd(input logic [7:0] c);
    logic o;
    for (int i = 0; i < 8; i++) slot(c[i], o);
  endtask

  task automatic state_is(input string req, input logic es, input logic ew);
    chk(sel_o === es && wait_o === ew, req, {sel_o, wait_o}, {es, ew});
  endtask

  initial begin
    #(CLK_P * 200000);
    nerr++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end

  initial begin
    logic o;
    logic [63:0] rd;
    logic ok;
    exp_id = {8'h00, SER, FAM};
    exp_id[63:56] = ref_chk(exp_id, 56);

    repeat (3) @(negedge clk);
    chk(slot_ready_o === 1'b0 && tx_bit_o === 1'b1 && wait_o === 1'b1 && sel_o === 1'b0,
        "R2 reset state", {slot_ready_o, tx_bit_o, wait_o, sel_o}, 4'b0110);
    rst_n = 1'b1;
    repeat (55) @(negedge clk);
    chk(slot_ready_o === 1'b0, "R2 ready after 55 edges", slot_ready_o, 0);
    @(negedge clk);
    chk(slot_ready_o === 1'b1, "R2 ready after 56 edges", slot_ready_o, 1);

    // R3 R9: sweep every command code
    for (int c = 0; c < 256; c++) begin
      bus_reset();
      send_cmd(8'(c));
      if (c == 8'h33 || c == 8'h55 || c == 8'hF0) state_is("R3 active cmd", 1'b0, 1'b0);
      else if (c == 8'hCC)                       state_is("R7 select-all", 1'b1, 1'b0);
      else                                       state_is("R9 unknown or R8 resel clear", 1'b0, 1'b1);
    end

    // R1 R4: identity read
    bus_reset();
    send_cmd(8'h33);
    for (int i = 0; i < 64; i++) begin
      slot(1'b1, o);
      rd[i] = o;
    end
    chk(rd === exp_id, "R1 R4 identity read", rd, exp_id);
    chk(ref_chk(rd, 64) === 8'h00, "R1 check byte residue", ref_chk(rd, 64), 0);
    chk(rd[7:0] === 8'h2D, "R1 family byte", rd[7:0], 8'h2D);
    state_is("R4 selected after read", 1'b1, 1'b0);
    bus_reset();
    send_cmd(8'hA5);
    state_is("R8 read leaves flag clear", 1'b0, 1'b1);

    // R5: full match then reselect
    bus_reset();
    send_cmd(8'h55);
    for (int i = 0; i < 64; i++) slot(exp_id[i], o);
    state_is("R5 full match", 1'b1, 1'b0);
    bus_reset();
    send_cmd(8'hA5);
    state_is("R8 reselect after match", 1'b1, 1'b0);

    // R10: flag kept across reset in mid match (match clears flag though)
    bus_reset();
    send_cmd(8'h55);
    for (int i = 0; i < 10; i++) slot(exp_id[i], o);
    bus_reset();
    chk(sel_o === 1'b0 && wait_o === 1'b0 && tx_bit_o === 1'b1, "R10 reset mid match", {sel_o, wait_o, tx_bit_o}, 3'b001);
    send_cmd(8'hA5);
    state_is("R10 flag cleared by match start stays clear", 1'b0, 1'b1);

    // R7: select-all clears flag set by an earlier match
    bus_reset();
    send_cmd(8'h55);
    for (int i = 0; i < 64; i++) slot(exp_id[i], o);
    bus_reset();
    send_cmd(8'hCC);
    state_is("R7 select-all", 1'b1, 1'b0);
    bus_reset();
    send_cmd(8'hA5);
    state_is("R7 select-all clears flag", 1'b0, 1'b1);

    // R5 R11: mismatch at every position
    for (int p = 0; p < 64; p++) begin
      bus_reset();
      send_cmd(8'h55);
      ok = 1'b1;
      for (int i = 0; i < 64; i++) begin
        if (i >= p && tx_bit_o !== 1'b1) ok = 1'b0;
        slot(i == p ? ~exp_id[i] : exp_id[i], o);
        if (i == p) state_is("R5 mismatch drop", 1'b0, 1'b1);
      end
      chk(ok && wait_o === 1'b1, "R11 released during match", {ok, wait_o}, 2'b11);
    end

    // R6: full search then reselect
    bus_reset();
    send_cmd(8'hF0);
    ok = 1'b1;
    for (int i = 0; i < 64; i++) begin
      slot(1'b1, o); if (o !== exp_id[i]) ok = 1'b0;
      slot(1'b1, o); if (o !== ~exp_id[i]) ok = 1'b0;
      slot(exp_id[i], o);
    end
    chk(ok, "R6 true/complement slots", ok, 1);
    state_is("R6 search complete", 1'b1, 1'b0);
    bus_reset();
    send_cmd(8'hA5);
    state_is("R8 reselect after search", 1'b1, 1'b0);
    bus_reset();
    chk(sel_o === 1'b0 && tx_bit_o === 1'b1, "R10 reset leaves selected", {sel_o, tx_bit_o}, 2'b01);
    send_cmd(8'hA5);
    state_is("R10 flag kept across reset", 1'b1, 1'b0);

    // R6 R11: search dropout at every position
    for (int p = 0; p < 64; p++) begin
      bus_reset();
      send_cmd(8'hF0);
      ok = 1'b1;
      for (int i = 0; i < 64; i++) begin
        slot(1'b1, o); if (i > p && o !== 1'b1) ok = 1'b0;
        slot(1'b1, o); if (i > p && o !== 1'b1) ok = 1'b0;
        slot(i == p ? ~exp_id[i] : exp_id[i], o);
        if (i == p) state_is("R6 dropout", 1'b0, 1'b1);
      end
      chk(ok && wait_o === 1'b1, "R11 released after dropout", {ok, wait_o}, 2'b11);
    end

    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end
endmodule